// File: doc/BRIEF.md
# Prime-Modulus Linear Congruential Generator

This block produces a stream of 16-bit pseudo-random numbers. Each enabled clock it advances its state by one step of the affine recurrence r ← (75·r + 74) mod 65537. The modulus is the prime 2^16+1. The block computes the product and the increment directly. It then reduces the sum through a chain of fold stages, which use the fact that 2^16 ≡ −1 for this modulus. Each fold takes the high part away from the low part and, when the difference goes negative, adds the modulus back. No divider is needed.

The multiplier 75 is a primitive root of 65537, so the affine map has exactly one fixed point, 65536. Every other state lies on a single cycle of length 65536. The state register is 17 bits wide so that the reduction stays exact. A filter on the seed path keeps the fixed point out of the register, so the visible output is always the 16-bit state.

A controller with three named states records what happened on the last clock edge. ST_IDLE means nothing advanced, either because of a reset or because enable was low. ST_FRESH means the generator took a step. ST_LOADED means a seed was written. The controller moves on every clock edge, according to the inputs sampled at that edge:
- load high → ST_LOADED
- otherwise enable high → ST_FRESH
- otherwise → ST_IDLE

Reset forces ST_IDLE. The valid flag is high only in ST_FRESH.

Top module: `prime_lcg_gen`

## Requirements
- R1: When `en` is high and `load` is low at a clock edge, the output one cycle later equals (75 × previous output + 74) mod 65537.
- R2: Starting from seed 0 with `en` held high, the output first returns to 0 after exactly 65536 steps. Since every output is 16 bits, each value 0..65535 appears once per period.
- R3: `rnd_vld` is high in the cycle after an edge that advanced the generator (`en` high, `load` low).
- R4: When `en` and `load` are both low at an edge, `rnd` holds its value and `rnd_vld` is low in the next cycle.
- R5: `load` has priority over `en`. After an edge with `load` high and `seed` ≤ 65535, `rnd` equals `seed[15:0]` and `rnd_vld` is low.
- R6: A loaded `seed` with bit 16 set (any value from 65536 to 131071) puts 0 into the state.
- R7: After an edge with `rst` high, `rnd` equals the reset seed 1 and `rnd_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the generator by one step |
| load | input | 1 | Write `seed` into the state; overrides `en` |
| seed | input | 17 | Seed value; values of 65536 and above load 0 |
| rnd | output | 16 | Current pseudo-random value |
| rnd_vld | output | 1 | High in the cycle after a step |

## Verification
The bench builds the block with its default parameters: width 16, multiplier 75, increment 74 and two fold stages. These are the only values for which the full-period property is claimed. The 65536-step cycle is short enough to walk completely. The bench compares every state along it against an integer model. It also confirms that seed 0 returns only at step 65536, which proves that every 16-bit value is reached.

The bench drives loads at the edges of the seed range, 0, 65535, 65536 and 131071. It also interleaves idle cycles between steps, which exercises every controller transition.

// File: rtl/prime_lcg_pkg.sv
package prime_lcg_pkg;

    // Controller state: what the last clock edge did to the generator.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FRESH  = 2'd1,
        ST_LOADED = 2'd2
    } lcg_st_e;

    // Command decoded from the inputs at an edge.
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } lcg_cmd_e;

endpackage

// File: rtl/prime_lcg_fold.sv
// One reduction stage modulo 2^W+1: y = lo - hi (+ modulus if negative).
module prime_lcg_fold #(
    parameter int W    = 16,
    parameter int IN_W = 24
) (
    input  logic [IN_W-1:0] x,
    output logic [IN_W-1:0] y
);
    localparam int HI_W = IN_W - W;
    localparam logic [IN_W:0] MODV =
        {{(IN_W-W){1'b0}}, 1'b1, {(W-1){1'b0}}, 1'b1};

    logic [IN_W:0] lo_ext;
    logic [IN_W:0] hi_ext;
    logic [IN_W:0] diff;
    logic [IN_W:0] wrapped;

    always_comb begin
        lo_ext  = {{(IN_W+1-W){1'b0}}, x[W-1:0]};
        hi_ext  = {{(W+1){1'b0}}, x[IN_W-1:W]};
        diff    = lo_ext - hi_ext;
        wrapped = diff + MODV;
        if (diff[IN_W]) begin
            y = wrapped[IN_W-1:0];
        end else begin
            y = diff[IN_W-1:0];
        end
    end

    logic unused_hi;
    assign unused_hi = ^{hi_ext[IN_W:HI_W], wrapped[IN_W]};

endmodule

// File: rtl/prime_lcg_step.sv
// Combinational next state: (MULT*cur + INC) mod (2^W+1) via fold chain.
module prime_lcg_step #(
    parameter int W     = 16,
    parameter int MULT  = 75,
    parameter int INC   = 74,
    parameter int FOLDS = 2
) (
    input  logic [W:0] cur,
    output logic [W:0] nxt
);
    localparam int PROD_W = W + $clog2(MULT + 1) + 1;

    logic [PROD_W-1:0] chain [FOLDS+1];

    always_comb begin
        chain[0] = PROD_W'(cur) * PROD_W'(MULT) + PROD_W'(INC);
    end

    for (genvar g = 0; g < FOLDS; g++) begin : g_fold
        prime_lcg_fold #(
            .W    (W),
            .IN_W (PROD_W)
        ) u_fold (
            .x (chain[g]),
            .y (chain[g+1])
        );
    end

    assign nxt = chain[FOLDS][W:0];

    logic unused_top;
    assign unused_top = ^chain[FOLDS][PROD_W-1:W+1];

endmodule

// File: rtl/prime_lcg_seed.sv
// Keeps the fixed point (and anything at or above 2^W) out of the state.
module prime_lcg_seed #(
    parameter int W = 16
) (
    input  logic [W:0] seed_raw,
    output logic [W:0] seed_ok
);
    always_comb begin
        if (seed_raw[W]) begin
            seed_ok = '0;
        end else begin
            seed_ok = seed_raw;
        end
    end
endmodule

// File: rtl/prime_lcg_gen.sv
module prime_lcg_gen
    import prime_lcg_pkg::*;
#(
    parameter int W          = 16,
    parameter int MULT       = 75,
    parameter int INC        = 74,
    parameter int RESET_SEED = 1,
    parameter int FOLDS      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W:0]   seed,
    output logic [W-1:0] rnd,
    output logic         rnd_vld
);
    localparam logic [W:0] SEED_RST = (W+1)'(RESET_SEED);

    lcg_st_e    st_q, st_d;
    lcg_cmd_e   cmd;
    logic [W:0] state_q, state_d;
    logic [W:0] step_val;
    logic [W:0] seed_val;

    prime_lcg_step #(
        .W     (W),
        .MULT  (MULT),
        .INC   (INC),
        .FOLDS (FOLDS)
    ) u_step (
        .cur (state_q),
        .nxt (step_val)
    );

    prime_lcg_seed #(.W(W)) u_seed (
        .seed_raw (seed),
        .seed_ok  (seed_val)
    );

    // Command decode: load wins over enable.
    always_comb begin
        if (load) begin
            cmd = CMD_LOAD;
        end else if (en) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_NONE;
        end
    end

    // Transition and datapath selection.
    always_comb begin
        st_d    = ST_IDLE;
        state_d = state_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d    = ST_LOADED;
                state_d = seed_val;
            end
            CMD_STEP: begin
                st_d    = ST_FRESH;
                state_d = step_val;
            end
            default: begin
                st_d    = ST_IDLE;
                state_d = state_q;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            state_q <= SEED_RST;
        end else begin
            st_q    <= st_d;
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        rnd = state_q[W-1:0];
        unique case (st_q)
            ST_FRESH:  rnd_vld = 1'b1;
            ST_LOADED: rnd_vld = 1'b0;
            default:   rnd_vld = 1'b0;
        endcase
    end

    logic unused_msb;
    assign unused_msb = state_q[W];

endmodule

// File: rtl/prime_lcg_gen_chk.sv
module prime_lcg_gen_chk #(
    parameter int W          = 16,
    parameter int MULT       = 75,
    parameter int INC        = 74,
    parameter int RESET_SEED = 1
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         load,
    input logic [W:0]   seed,
    input logic [W-1:0] rnd,
    input logic         rnd_vld
);
    localparam longint MODL = (longint'(1) << W) + 1;

    // R1
    recurrence_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> (longint'(rnd) ==
            (longint'(MULT) * longint'($past(rnd)) + longint'(INC)) % MODL));

    // R3
    valid_after_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> rnd_vld);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> ($stable(rnd) && !rnd_vld));

    // R5
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !seed[W]) |=> (rnd == $past(seed[W-1:0]) && !rnd_vld));

    // R6
    load_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (load && seed[W]) |=> (rnd == '0 && !rnd_vld));

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rnd == W'(RESET_SEED) && !rnd_vld));

endmodule

bind prime_lcg_gen prime_lcg_gen_chk #(
    .W          (W),
    .MULT       (MULT),
    .INC        (INC),
    .RESET_SEED (RESET_SEED)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .load    (load),
    .seed    (seed),
    .rnd     (rnd),
    .rnd_vld (rnd_vld)
);

// File: tb/prime_lcg_gen_test.sv
module prime_lcg_gen_test;
    localparam int W    = 16;
    localparam int MULT = 75;
    localparam int INC  = 74;
    localparam int MODV = 65537;
    localparam int PERIOD = 65536;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         load = 1'b0;
    logic [W:0]   seed = '0;
    logic [W-1:0] rnd;
    logic         rnd_vld;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prime_lcg_gen uut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .load    (load),
        .seed    (seed),
        .rnd     (rnd),
        .rnd_vld (rnd_vld)
    );

    function automatic int model_next(input int r);
        return (MULT * r + INC) % MODV;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, return at the next falling edge.
    task automatic cycle(input logic e, input logic l, input int s);
        en   = e;
        load = l;
        seed = (W+1)'(s);
        @(negedge clk);
    endtask

    initial begin
        int exp_v;
        bit early;
        @(negedge clk);
        @(negedge clk);
        // R7 reset state
        check("R7 rnd", int'(rnd), 1);
        check("R7 vld", int'(rnd_vld), 0);
        rst = 1'b0;

        // R1/R3: steps from the reset seed
        exp_v = 1;
        for (int i = 0; i < 5; i++) begin
            cycle(1'b1, 1'b0, 0);
            exp_v = model_next(exp_v);
            check("R1 step", int'(rnd), exp_v);
            check("R3 vld", int'(rnd_vld), 1);
        end

        // R4: idle holds
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 1'b0, 0);
            check("R4 hold", int'(rnd), exp_v);
            check("R4 vld", int'(rnd_vld), 0);
        end
        cycle(1'b1, 1'b0, 0);
        exp_v = model_next(exp_v);
        check("R1 resume", int'(rnd), exp_v);
        check("R3 resume vld", int'(rnd_vld), 1);

        // R5: load beats enable
        cycle(1'b1, 1'b1, 12345);
        check("R5 load", int'(rnd), 12345);
        check("R5 vld", int'(rnd_vld), 0);
        cycle(1'b1, 1'b0, 0);
        check("R1 after load", int'(rnd), model_next(12345));
        check("R3 after load", int'(rnd_vld), 1);

        // R6: seeds with bit 16 set load 0
        cycle(1'b0, 1'b1, 65536);
        check("R6 65536", int'(rnd), 0);
        cycle(1'b0, 1'b0, 0);
        check("R6 hold", int'(rnd), 0);
        cycle(1'b0, 1'b1, 131071);
        check("R6 131071", int'(rnd), 0);

        // R1 at top of range
        cycle(1'b0, 1'b1, 65535);
        check("R5 top", int'(rnd), 65535);
        cycle(1'b1, 1'b0, 0);
        check("R1 top", int'(rnd), model_next(65535));

        // R2: full period from seed 0
        cycle(1'b0, 1'b1, 0);
        check("R5 zero", int'(rnd), 0);
        exp_v = 0;
        early = 1'b0;
        en = 1'b1;
        load = 1'b0;
        for (int i = 1; i <= PERIOD; i++) begin
            @(negedge clk);
            exp_v = model_next(exp_v);
            if (int'(rnd) != exp_v) check("R2 sequence", int'(rnd), exp_v);
            else n_cmp++;
            if (i < PERIOD && rnd == '0) early = 1'b1;
        end
        en = 1'b0;
        check("R2 early return", int'(early), 0);
        check("R2 period end", int'(rnd), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule